// File: doc/BRIEF.md
# Oscillator Warm-up Delay Counter

This block makes the rest of a chip wait after power-up or a wake from STOP until an oscillator or supply has had time to settle. It counts pulses of a chosen clock source through a small prescaler into a 14-bit counter. Only the top 8 bits of that counter are compared with a programmed compare value. When they match, counting stops and the block raises `done`. After a reset it also lowers the reset hold it drives to the CPU and peripherals.

Both clock sources are modelled as single-cycle enable pulses in one fast clock domain. A warm-up can start in three ways:
- Reset release always counts the high-frequency source and uses fixed power-on settings.
- Software can start a warm-up on the source held in its select register.
- Leaving STOP starts a hardware warm-up on whichever source was driving the system clock when STOP was entered. The source select register is ignored in that case.

A STOP that interrupts a software warm-up freezes the count. The count then resumes from the same value.

Top module: `warmup_timer`

## Requirements
- R1: After reset, `holdRst` is 1 and `done` is 0. The compare value resets to 0x66, the divide select to binary 11 and the source select to 0. The reset warm-up counts only `hfTick` pulses and ignores `lfTick`. `holdRst` falls and `done` rises after exactly 102×512 HF pulses. `holdRst` never rises again until the next reset.
- R2: With compare value N (1..255) and divide select d (00, 01, 10, 11 meaning ÷1, ÷2, ÷4, ÷8), a warm-up completes on exactly the N×2^(6+d)-th selected pulse. `done` is visible one clock after the edge that samples that pulse.
- R3: A `swStart` pulse, taken when `stopIn` is low and no reset warm-up is running, clears the count and drops `done`. It starts counting the source named by the source select (0 = `hfTick`, 1 = `lfTick`). Pulses of the other source have no effect.
- R4: A compare value of 0 completes the warm-up on the first selected pulse after the start.
- R5: `done` stays high after a match, whatever pulses arrive, until the next warm-up start.
- R6: When `stopIn` falls after a STOP entered while idle, a warm-up starts from zero and `done` drops. This warm-up counts the source given by `stopSrc` as sampled at STOP entry (0 = HF, 1 = LF), regardless of the source select.
- R7: A STOP entered during a software warm-up freezes the count, and pulses during STOP are ignored. After `stopIn` falls, counting continues from the held value without clearing.
- R8: A `cfgWe` pulse loads the source select, divide select and compare value, which the next warm-up uses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rstN | input | 1 | Asynchronous active-low power-on/external reset |
| hfTick | input | 1 | High-frequency source enable pulse |
| lfTick | input | 1 | Low-frequency source enable pulse |
| cfgWe | input | 1 | Load strobe for the configuration fields |
| cfgSrcSel | input | 1 | Software warm-up source: 0 HF, 1 LF |
| cfgDivSel | input | 2 | Prescaler select: ÷1, ÷2, ÷4, ÷8 |
| cfgCmp | input | 8 | Compare value for the counter's upper 8 bits |
| swStart | input | 1 | Start a software warm-up |
| stopIn | input | 1 | High while the chip is in STOP |
| stopSrc | input | 1 | Source driving the system clock at STOP entry: 0 HF, 1 LF |
| holdRst | output | 1 | CPU/peripheral reset hold, high until the first match |
| done | output | 1 | Warm-up complete level |

## Verification
The bench counts pulses to the exact completing pulse and checks one pulse short of it. This catches a prescaler that divides by the wrong power of two, and a comparison made on the current rather than the next count. It drives the unselected source while a warm-up runs, and sets the source select against `stopSrc` before a STOP wake. A design that honours the wrong select completes early or never. A STOP inserted mid-way through a software warm-up must add no pulses and lose none. A design that clears on wake or counts during STOP finishes off by the frozen amount. A zero compare value must finish on the first pulse rather than hang.

// File: rtl/warmup_pkg.sv
package warmup_pkg;

  typedef enum logic [2:0] {
    ST_RSTWARM,
    ST_IDLE,
    ST_SWWARM,
    ST_STOP,
    ST_STOPWARM
  } wuState_t;

  typedef struct packed {
    logic clrCnt;
    logic run;
    logic useLf;
  } wuStrobe_t;

endpackage

// File: rtl/warmup_ctrl.sv
module warmup_ctrl
  import warmup_pkg::*;
#(
  parameter int CMP_W   = 8,
  parameter int DIV_W   = 2,
  parameter logic [CMP_W-1:0] RST_CMP = 8'h66,
  parameter logic [DIV_W-1:0] RST_DIV = 2'b11
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWe,
  input  logic             cfgSrcSel,
  input  logic [DIV_W-1:0] cfgDivSel,
  input  logic [CMP_W-1:0] cfgCmp,
  input  logic             swStart,
  input  logic             stopIn,
  input  logic             stopSrc,
  input  logic             hit,
  output wuStrobe_t        stb,
  output logic [DIV_W-1:0] divSel,
  output logic [CMP_W-1:0] cmpVal,
  output logic             holdRst,
  output logic             done
);

  wuState_t state;
  logic     srcSelR;
  logic     activeLf;
  logic     stopLf;
  logic     resumeSw;
  logic     warmState;
  logic     canStart;
  logic     startSw;
  logic     stopWake;

  assign warmState = (state == ST_RSTWARM) || (state == ST_SWWARM) || (state == ST_STOPWARM);
  assign canStart  = (state == ST_IDLE) || (state == ST_SWWARM) || (state == ST_STOPWARM);
  assign startSw   = swStart && !stopIn && canStart;
  assign stopWake  = (state == ST_STOP) && !stopIn && !resumeSw;

  always_comb begin
    stb.clrCnt = startSw || stopWake;
    stb.run    = warmState && !stopIn;
    stb.useLf  = activeLf;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srcSelR <= 1'b0;
      divSel  <= RST_DIV;
      cmpVal  <= RST_CMP;
    end else if (cfgWe) begin
      srcSelR <= cfgSrcSel;
      divSel  <= cfgDivSel;
      cmpVal  <= cfgCmp;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_RSTWARM;
      holdRst  <= 1'b1;
      done     <= 1'b0;
      activeLf <= 1'b0;
      stopLf   <= 1'b0;
      resumeSw <= 1'b0;
    end else begin
      case (state)
        ST_RSTWARM: begin
          if (hit) begin
            state   <= ST_IDLE;
            holdRst <= 1'b0;
            done    <= 1'b1;
          end
        end
        ST_STOP: begin
          if (!stopIn) begin
            if (resumeSw) begin
              state <= ST_SWWARM;
            end else begin
              state    <= ST_STOPWARM;
              activeLf <= stopLf;
              done     <= 1'b0;
            end
          end
        end
        default: begin
          if (stopIn) begin
            state    <= ST_STOP;
            resumeSw <= (state == ST_SWWARM);
            stopLf   <= stopSrc;
          end else if (swStart) begin
            state    <= ST_SWWARM;
            activeLf <= srcSelR;
            done     <= 1'b0;
          end else if (state != ST_IDLE && hit) begin
            state <= ST_IDLE;
            done  <= 1'b1;
          end
        end
      endcase
    end
  end

  // R1: the CPU hold and the done flag are never both high
  a_r1_hold_excludes_done: assert property (@(posedge clk) disable iff (!rstN)
    holdRst |-> !done);
  // R1: the reset warm-up only ever counts the high-frequency source
  a_r1_reset_uses_hf: assert property (@(posedge clk) disable iff (!rstN)
    holdRst |-> !stb.useLf);
  // R1: the hold never returns once released
  a_r1_hold_stays_low: assert property (@(posedge clk) disable iff (!rstN)
    !holdRst |=> !holdRst);
  // R5: done only falls when a new warm-up clears the counter
  a_r5_done_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (done && !stb.clrCnt) |=> done);
  // R7: nothing counts while STOP is active
  a_r7_no_run_in_stop: assert property (@(posedge clk) disable iff (!rstN)
    stopIn && !holdRst |-> !stb.run);

endmodule

// File: rtl/warmup_datapath.sv
module warmup_datapath
  import warmup_pkg::*;
#(
  parameter int CNT_W   = 14,
  parameter int CMP_W   = 8,
  parameter int PRESC_W = 3,
  parameter int DIV_W   = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             hfTick,
  input  logic             lfTick,
  input  wuStrobe_t        stb,
  input  logic [DIV_W-1:0] divSel,
  input  logic [CMP_W-1:0] cmpVal,
  output logic             hit
);

  localparam int LSB_DROP = CNT_W - CMP_W;

  logic [CNT_W-1:0]   cnt;
  logic [CNT_W-1:0]   cntNext;
  logic [PRESC_W-1:0] presc;
  logic [PRESC_W-1:0] prescMask;
  logic               tickEn;
  logic               advance;

  assign tickEn  = stb.run && (stb.useLf ? lfTick : hfTick);
  assign cntNext = cnt + 1'b1;

  always_comb begin
    for (int i = 0; i < PRESC_W; i++) begin
      prescMask[i] = (i < int'(divSel));
    end
  end

  assign advance = &(presc | ~prescMask);
  assign hit = tickEn && ((cmpVal == '0) ||
               (advance && (cntNext[CNT_W-1 -: CMP_W] == cmpVal)));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt   <= '0;
      presc <= '0;
    end else if (stb.clrCnt) begin
      cnt   <= '0;
      presc <= '0;
    end else if (tickEn) begin
      presc <= presc + 1'b1;
      if (advance) cnt <= cntNext;
    end
  end

  // R6: a warm-up start leaves the counter at zero
  a_r6_clear_to_zero: assert property (@(posedge clk) disable iff (!rstN)
    stb.clrCnt |=> (cnt == '0));
  // R7: a stopped or idle block holds its count
  a_r7_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.run && !stb.clrCnt) |=> $stable(cnt));
  // R2: the counter steps by at most one per cycle
  a_r2_single_step: assert property (@(posedge clk) disable iff (!rstN)
    !stb.clrCnt |=> ((cnt == $past(cnt)) || (cnt == $past(cnt) + 1'b1)));
  // R2: the upper bits never pass a nonzero compare value
  a_r2_no_overshoot: assert property (@(posedge clk) disable iff (!rstN)
    (stb.run && cmpVal != '0 && !stb.clrCnt) |-> (cnt[CNT_W-1 -: CMP_W] <= cmpVal) || !$stable(cmpVal));

  localparam int UNUSED_DROP = LSB_DROP;

endmodule

// File: rtl/warmup_timer.sv
module warmup_timer
  import warmup_pkg::*;
#(
  parameter int CNT_W   = 14,
  parameter int CMP_W   = 8,
  parameter int PRESC_W = 3,
  parameter int DIV_W   = $clog2(PRESC_W + 1),
  parameter logic [CMP_W-1:0] RST_CMP = 8'h66,
  parameter logic [DIV_W-1:0] RST_DIV = 2'b11
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             hfTick,
  input  logic             lfTick,
  input  logic             cfgWe,
  input  logic             cfgSrcSel,
  input  logic [DIV_W-1:0] cfgDivSel,
  input  logic [CMP_W-1:0] cfgCmp,
  input  logic             swStart,
  input  logic             stopIn,
  input  logic             stopSrc,
  output logic             holdRst,
  output logic             done
);

  wuStrobe_t        stb;
  logic [DIV_W-1:0] divSel;
  logic [CMP_W-1:0] cmpVal;
  logic             hit;

  warmup_ctrl #(
    .CMP_W(CMP_W), .DIV_W(DIV_W), .RST_CMP(RST_CMP), .RST_DIV(RST_DIV)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .cfgWe(cfgWe), .cfgSrcSel(cfgSrcSel), .cfgDivSel(cfgDivSel), .cfgCmp(cfgCmp),
    .swStart(swStart), .stopIn(stopIn), .stopSrc(stopSrc), .hit(hit),
    .stb(stb), .divSel(divSel), .cmpVal(cmpVal),
    .holdRst(holdRst), .done(done)
  );

  warmup_datapath #(
    .CNT_W(CNT_W), .CMP_W(CMP_W), .PRESC_W(PRESC_W), .DIV_W(DIV_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .hfTick(hfTick), .lfTick(lfTick),
    .stb(stb), .divSel(divSel), .cmpVal(cmpVal), .hit(hit)
  );

endmodule

// File: tb/warmup_timer_test.sv
module warmup_timer_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       hfTick = 1'b0, lfTick = 1'b0;
  logic       cfgWe = 1'b0, cfgSrcSel = 1'b0;
  logic [1:0] cfgDivSel = 2'b00;
  logic [7:0] cfgCmp = 8'h00;
  logic       swStart = 1'b0, stopIn = 1'b0, stopSrc = 1'b0;
  logic       holdRst, done;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  warmup_timer uut (
    .clk(clk), .rstN(rstN), .hfTick(hfTick), .lfTick(lfTick),
    .cfgWe(cfgWe), .cfgSrcSel(cfgSrcSel), .cfgDivSel(cfgDivSel), .cfgCmp(cfgCmp),
    .swStart(swStart), .stopIn(stopIn), .stopSrc(stopSrc),
    .holdRst(holdRst), .done(done)
  );

  task automatic check(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic pulses(input int n, input bit useLf);
    for (int i = 0; i < n; i++) begin
      if (useLf) lfTick = 1'b1; else hfTick = 1'b1;
      @(negedge clk);
      lfTick = 1'b0;
      hfTick = 1'b0;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic configure(input logic src, input logic [1:0] dv, input logic [7:0] cmp);
    cfgSrcSel = src; cfgDivSel = dv; cfgCmp = cmp; cfgWe = 1'b1;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic startSw();
    swStart = 1'b1;
    @(negedge clk);
    swStart = 1'b0;
    check("R3", "done low after start", done, 1'b0);
  endtask

  // completes on exactly the n-th pulse of the chosen source
  task automatic expectAfter(input string req, input int n, input bit useLf);
    pulses(n - 1, useLf);
    check(req, "done before last pulse", done, 1'b0);
    pulses(1, useLf);
    check(req, "done after last pulse", done, 1'b1);
  endtask

  task automatic testReset();
    idle(2);
    check("R1", "holdRst in reset", holdRst, 1'b1);
    check("R1", "done in reset", done, 1'b0);
    rstN = 1'b1;
    pulses(100, 1'b1);
    check("R1", "LF ignored in reset warm-up", done, 1'b0);
    expectAfter("R1", 102 * 512, 1'b0);
    check("R1", "holdRst released", holdRst, 1'b0);
  endtask

  task automatic testSw();
    configure(1'b0, 2'b00, 8'd3);
    startSw();
    pulses(50, 1'b1);
    check("R3", "LF ignored when HF selected", done, 1'b0);
    expectAfter("R8", 3 * 64 - 0, 1'b0);
  endtask

  task automatic testDivs();
    configure(1'b0, 2'b01, 8'd2);
    startSw();
    expectAfter("R2", 2 * 128, 1'b0);
    configure(1'b0, 2'b10, 8'd2);
    startSw();
    expectAfter("R2", 2 * 256, 1'b0);
    configure(1'b0, 2'b11, 8'd1);
    startSw();
    expectAfter("R2", 512, 1'b0);
  endtask

  task automatic testLf();
    configure(1'b1, 2'b00, 8'd1);
    startSw();
    pulses(200, 1'b0);
    check("R3", "HF ignored when LF selected", done, 1'b0);
    expectAfter("R3", 64, 1'b1);
  endtask

  task automatic testZero();
    configure(1'b0, 2'b11, 8'd0);
    startSw();
    idle(5);
    check("R4", "no pulse yet", done, 1'b0);
    pulses(1, 1'b0);
    check("R4", "first pulse completes", done, 1'b1);
    pulses(300, 1'b0);
    check("R5", "done held after extra pulses", done, 1'b1);
    check("R1", "holdRst stays low", holdRst, 1'b0);
  endtask

  task automatic testStopWake(input logic src);
    configure(~src, 2'b00, 8'd1);
    stopSrc = src;
    stopIn = 1'b1;
    @(negedge clk);
    stopSrc = ~src;
    pulses(80, src);
    check("R5", "done held through STOP", done, 1'b1);
    stopIn = 1'b0;
    @(negedge clk);
    check("R6", "done drops on wake", done, 1'b0);
    pulses(100, ~src);
    check("R6", "select register ignored on wake", done, 1'b0);
    expectAfter("R6", 64, src);
  endtask

  task automatic testStopFreeze();
    configure(1'b0, 2'b00, 8'd2);
    startSw();
    pulses(50, 1'b0);
    stopIn = 1'b1;
    @(negedge clk);
    pulses(100, 1'b0);
    check("R7", "no completion during STOP", done, 1'b0);
    stopIn = 1'b0;
    @(negedge clk);
    expectAfter("R7", 128 - 50, 1'b0);
  endtask

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    finishRun();
  end

  initial begin
    @(negedge clk);
    testReset();
    testSw();
    testDivs();
    testLf();
    testZero();
    testStopWake(1'b0);
    testStopWake(1'b1);
    testStopFreeze();
    finishRun();
  end

endmodule